// File: doc/BRIEF.md
# Per-Region Memory Wait-State Generator

This block produces the wait line that stretches memory bus cycles of a small 8-bit processor. A host-visible 8-bit configuration register holds a 2-bit wait code for each of four memory regions: on-chip ROM, external memory selected by the RAM chip select, external memory selected by the ROM chip select, and any other external memory. When a memory request starts, the block picks the region being accessed. It then loads a down-counter with that region's decoded count and holds its wait output active until the counter reaches zero.

A global wait count of 0 to 3 cycles applies to every memory access. It runs on a second counter that starts with the same request. The two counters and an external wait input are combined by OR onto the wait output, so the longer stretch wins. Address decoding for the chip selects, the CPU core and I/O-cycle waits are handled elsewhere. The block only receives the region indicators and a one-cycle request-start pulse.

Top module: `memwait_gen`

## Requirements
- R1: The configuration register is written when `io_wr` is high and `io_addr` equals 0xD8. It reads back on `io_rdata` while `io_rd` is high at that address. Any other address reads as 0x00 and does not change the register.
- R2: After reset the configuration register holds 0xFF, so every region starts at four wait states.
- R3: The field at bits 7:6 serves RAM-select accesses and bits 5:4 serves ROM-select accesses. Bits 3:2 serve on-chip ROM and bits 1:0 serve other external memory. Region priority is on-chip ROM first, then the RAM select, then the ROM select; with none of these the access uses bits 1:0.
- R4: Each 2-bit field decodes as 00 to zero waits, 01 to one, 10 to two and 11 to four.
- R5: After the clock edge that samples `mem_start` high, `wait_o` is high for exactly N consecutive cycles, where N is the decoded count. It is then low, provided the global count is not larger and `ext_wait` is low.
- R6: The region and its count are captured at the request start. A register write during the stretched cycle does not change that cycle's wait length.
- R7: `glob_waits` (0 to 3) is captured at the request start and runs its own stretch. `wait_o` is the OR of both, so the stretch equals the larger count.
- R8: While `ext_wait` is high, `wait_o` is high.
- R9: Without a `mem_start` pulse neither counter starts, so idle and I/O cycles see no generated wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | Host I/O write strobe |
| io_rd | input | 1 | Host I/O read strobe |
| io_addr | input | 8 | Host I/O address |
| io_wdata | input | 8 | Host I/O write data |
| io_rdata | output | 8 | Host I/O read data |
| mem_start | input | 1 | One-cycle pulse at the start of a memory request |
| sel_onchip | input | 1 | Access targets on-chip ROM |
| sel_ram | input | 1 | RAM chip select asserted |
| sel_rom | input | 1 | ROM chip select asserted |
| glob_waits | input | 2 | Global wait count for all memory accesses |
| ext_wait | input | 1 | External wait request |
| wait_o | output | 1 | Combined wait output |

## Verification
A table sets each region's field to every code while the other fields hold a different value. A stretch of the right length therefore shows both the field position and the decoding; the zero-code rows place 11 in the other fields so that a wrong field shows up as four waits. Rows with both chip selects, or on-chip ROM together with a select, separate the priority order. Rows where the global count exceeds the regional count, and the reverse, show that the OR picks the longer stretch. Directed cases cover the reset value, writes to a neighbouring address, a write in the middle of a stretched cycle, the external wait, and I/O traffic without a request.

// File: rtl/memwait_pkg.sv
package memwait_pkg;

   // Region index equals the field index inside the configuration byte.
   typedef enum logic [1:0] {
      RGN_OTHER  = 2'd0,
      RGN_ONCHIP = 2'd1,
      RGN_ROM    = 2'd2,
      RGN_RAM    = 2'd3
   } region_e;

   localparam int unsigned NUM_REGIONS = 4;

   // Translate a field code to a wait count: all-ones maps to top_waits.
   function automatic int unsigned code_to_waits(input int unsigned code,
                                                 input int unsigned field_w,
                                                 input int unsigned top_waits);
      int unsigned all_ones;
      all_ones = (1 << field_w) - 1;
      return (code == all_ones) ? top_waits : code;
   endfunction

endpackage

// File: rtl/memwait_cfg_reg.sv
module memwait_cfg_reg #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 8'hD8,
   parameter logic [DATA_W-1:0] RST_VAL  = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic [DATA_W-1:0] cfg_q
);

   logic hit;

   assign hit = (io_addr == CFG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= RST_VAL;
      end else if (io_wr && hit) begin
         cfg_q <= io_wdata;
      end
   end

   always_comb begin
      io_rdata = '0;
      if (io_rd && hit) begin
         io_rdata = cfg_q;
      end
   end

endmodule

// File: rtl/memwait_region_sel.sv
module memwait_region_sel
   import memwait_pkg::*;
#(
   parameter int unsigned FIELD_W   = 2,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CNT_W     = 3,
   parameter int unsigned TOP_WAITS = 4
) (
   input  logic [DATA_W-1:0] cfg,
   input  logic              sel_onchip,
   input  logic              sel_ram,
   input  logic              sel_rom,
   output region_e           region,
   output logic [CNT_W-1:0]  region_cnt
);

   logic [CNT_W-1:0] field_cnt [NUM_REGIONS];

   // Decode every field in parallel; the region picks one afterwards.
   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_field
      logic [FIELD_W-1:0] code;
      assign code         = cfg[g*FIELD_W +: FIELD_W];
      assign field_cnt[g] = CNT_W'(code_to_waits(int'(code), FIELD_W, TOP_WAITS));
   end

   always_comb begin
      if (sel_onchip) begin
         region = RGN_ONCHIP;
      end else if (sel_ram) begin
         region = RGN_RAM;
      end else if (sel_rom) begin
         region = RGN_ROM;
      end else begin
         region = RGN_OTHER;
      end
   end

   assign region_cnt = field_cnt[region];

endmodule

// File: rtl/memwait_down_ctr.sv
module memwait_down_ctr #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             busy
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != '0);

endmodule

// File: rtl/memwait_gen.sv
module memwait_gen
   import memwait_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned FIELD_W   = 2,
   parameter int unsigned GLB_W     = 2,
   parameter int unsigned TOP_WAITS = 4,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 8'hD8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        io_wr,
   input  logic                        io_rd,
   input  logic [ADDR_W-1:0]           io_addr,
   input  logic [NUM_REGIONS*FIELD_W-1:0] io_wdata,
   output logic [NUM_REGIONS*FIELD_W-1:0] io_rdata,
   input  logic                        mem_start,
   input  logic                        sel_onchip,
   input  logic                        sel_ram,
   input  logic                        sel_rom,
   input  logic [GLB_W-1:0]            glob_waits,
   input  logic                        ext_wait,
   output logic                        wait_o
);

   localparam int unsigned DATA_W  = NUM_REGIONS * FIELD_W;
   localparam int unsigned GLB_MAX = (1 << GLB_W) - 1;
   localparam int unsigned MAX_W   = (TOP_WAITS > GLB_MAX) ? TOP_WAITS : GLB_MAX;
   localparam int unsigned CNT_W   = $clog2(MAX_W + 1) + 1;
   localparam logic [DATA_W-1:0] RST_VAL = '1;

   if (FIELD_W < 2) begin : g_chk_field
      $error("FIELD_W must be at least 2");
   end
   if (TOP_WAITS < (1 << FIELD_W) - 1) begin : g_chk_top
      $error("TOP_WAITS must not be below the largest plain code");
   end
   if (CNT_W <= GLB_W) begin : g_chk_cnt
      $error("counter narrower than global wait field");
   end

   logic [DATA_W-1:0] cfg_q;
   region_e           region;
   logic [CNT_W-1:0]  region_load;
   logic [CNT_W-1:0]  glob_load;
   logic [CNT_W-1:0]  rgn_cnt;
   logic [CNT_W-1:0]  glb_cnt;
   logic              rgn_busy;
   logic              glb_busy;

   memwait_cfg_reg #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .CFG_ADDR(CFG_ADDR),
      .RST_VAL (RST_VAL)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_wr   (io_wr),
      .io_rd   (io_rd),
      .io_addr (io_addr),
      .io_wdata(io_wdata),
      .io_rdata(io_rdata),
      .cfg_q   (cfg_q)
   );

   memwait_region_sel #(
      .FIELD_W  (FIELD_W),
      .DATA_W   (DATA_W),
      .CNT_W    (CNT_W),
      .TOP_WAITS(TOP_WAITS)
   ) u_sel (
      .cfg       (cfg_q),
      .sel_onchip(sel_onchip),
      .sel_ram   (sel_ram),
      .sel_rom   (sel_rom),
      .region    (region),
      .region_cnt(region_load)
   );

   assign glob_load = {{(CNT_W-GLB_W){1'b0}}, glob_waits};

   memwait_down_ctr #(.CNT_W(CNT_W)) u_rgn_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (mem_start),
      .load_val(region_load),
      .cnt     (rgn_cnt),
      .busy    (rgn_busy)
   );

   memwait_down_ctr #(.CNT_W(CNT_W)) u_glb_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (mem_start),
      .load_val(glob_load),
      .cnt     (glb_cnt),
      .busy    (glb_busy)
   );

   assign wait_o = rgn_busy | glb_busy | ext_wait;

endmodule

// File: rtl/memwait_chk.sv
module memwait_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned GLB_W     = 2,
   parameter int unsigned CNT_W     = 4,
   parameter int unsigned TOP_WAITS = 4,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 8'hD8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_rd,
   input logic [ADDR_W-1:0] io_addr,
   input logic [DATA_W-1:0] io_rdata,
   input logic              mem_start,
   input logic [GLB_W-1:0]  glob_waits,
   input logic              ext_wait,
   input logic              wait_o,
   input logic [CNT_W-1:0]  rgn_cnt,
   input logic [CNT_W-1:0]  glb_cnt
);

   assert_rdata_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr != CFG_ADDR) |-> io_rdata == '0);

   assert_cnt_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_cnt <= CNT_W'(TOP_WAITS));

   assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_start && rgn_cnt != '0) |=> rgn_cnt == CNT_W'($past(rgn_cnt) - 1'b1));

   assert_glob_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_start |=> glb_cnt == CNT_W'($past(glob_waits)));

   assert_or_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rgn_cnt != '0 || glb_cnt != '0) |-> wait_o);

   assert_ext_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ext_wait |-> wait_o);

   assert_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_start && rgn_cnt == '0 && glb_cnt == '0) |=> (rgn_cnt == '0 && glb_cnt == '0));

endmodule

bind memwait_gen memwait_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .GLB_W    (GLB_W),
   .CNT_W    (CNT_W),
   .TOP_WAITS(TOP_WAITS),
   .CFG_ADDR (CFG_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_rd     (io_rd),
   .io_addr   (io_addr),
   .io_rdata  (io_rdata),
   .mem_start (mem_start),
   .glob_waits(glob_waits),
   .ext_wait  (ext_wait),
   .wait_o    (wait_o),
   .rgn_cnt   (rgn_cnt),
   .glb_cnt   (glb_cnt)
);

// File: tb/tb_memwait_gen.sv
module tb_memwait_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       io_wr = 1'b0;
   logic       io_rd = 1'b0;
   logic [7:0] io_addr = 8'h00;
   logic [7:0] io_wdata = 8'h00;
   logic [7:0] io_rdata;
   logic       mem_start = 1'b0;
   logic       sel_onchip = 1'b0;
   logic       sel_ram = 1'b0;
   logic       sel_rom = 1'b0;
   logic [1:0] glob_waits = 2'd0;
   logic       ext_wait = 1'b0;
   logic       wait_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   memwait_gen dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_wr     (io_wr),
      .io_rd     (io_rd),
      .io_addr   (io_addr),
      .io_wdata  (io_wdata),
      .io_rdata  (io_rdata),
      .mem_start (mem_start),
      .sel_onchip(sel_onchip),
      .sel_ram   (sel_ram),
      .sel_rom   (sel_rom),
      .glob_waits(glob_waits),
      .ext_wait  (ext_wait),
      .wait_o    (wait_o)
   );

   // {cfg[7:0], onchip, ram, rom, glob[1:0], expected stretch[2:0]}
   localparam int NV = 20;
   localparam logic [15:0] VEC [NV] = '{
      {8'h3F, 3'b010, 2'd0, 3'd0}, {8'h40, 3'b010, 2'd0, 3'd1},
      {8'h80, 3'b010, 2'd0, 3'd2}, {8'hC0, 3'b010, 2'd0, 3'd4},
      {8'hCF, 3'b001, 2'd0, 3'd0}, {8'h10, 3'b001, 2'd0, 3'd1},
      {8'h20, 3'b001, 2'd0, 3'd2}, {8'h30, 3'b001, 2'd0, 3'd4},
      {8'hF3, 3'b100, 2'd0, 3'd0}, {8'h04, 3'b100, 2'd0, 3'd1},
      {8'h08, 3'b100, 2'd0, 3'd2}, {8'h0C, 3'b100, 2'd0, 3'd4},
      {8'hFC, 3'b000, 2'd0, 3'd0}, {8'h01, 3'b000, 2'd0, 3'd1},
      {8'h02, 3'b000, 2'd0, 3'd2}, {8'h03, 3'b000, 2'd0, 3'd4},
      {8'h60, 3'b011, 2'd0, 3'd1}, {8'h48, 3'b110, 2'd0, 3'd2},
      {8'h40, 3'b010, 2'd3, 3'd3}, {8'hC0, 3'b010, 2'd2, 3'd4}
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic io_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      io_wr = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      io_rd = 1'b1; io_addr = a;
      #1 d = io_rdata;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   // Start a request, then count the cycles wait_o stays high.
   task automatic measure(input logic [2:0] sel, input logic [1:0] g, output int n);
      @(negedge clk);
      mem_start = 1'b1;
      {sel_onchip, sel_ram, sel_rom} = sel;
      glob_waits = g;
      @(negedge clk);
      mem_start = 1'b0;
      {sel_onchip, sel_ram, sel_rom} = 3'b000;
      glob_waits = 2'd0;
      n = 0;
      for (int k = 0; k < 8; k++) begin
         if (wait_o) n++;
         @(negedge clk);
      end
   endtask

   initial begin
      #1_600_000;
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2: reset value and reset stretch for the other region
      io_read(8'hD8, rd);
      check("R2 reset value", rd, 8'hFF);
      measure(3'b000, 2'd0, n);
      check("R2 reset stretch", n, 4);

      // Table: R3 field placement, R4 encoding, R5 length, R7 OR
      for (int i = 0; i < NV; i++) begin
         io_write(8'hD8, VEC[i][15:8]);
         measure(VEC[i][7:5], VEC[i][4:3], n);
         check($sformatf("R3/R4/R5/R7 row %0d", i), n, int'(VEC[i][2:0]));
      end

      // R1: readback, neighbour address write ignored, neighbour read zero
      io_write(8'hD8, 8'h5A);
      io_read(8'hD8, rd);
      check("R1 readback", rd, 8'h5A);
      io_write(8'hD9, 8'h12);
      io_read(8'hD8, rd);
      check("R1 foreign write ignored", rd, 8'h5A);
      io_read(8'hD9, rd);
      check("R1 foreign read zero", rd, 8'h00);

      // R6: write during a stretched RAM cycle keeps its length
      io_write(8'hD8, 8'hC0);
      @(negedge clk);
      mem_start = 1'b1; sel_ram = 1'b1;
      @(negedge clk);
      mem_start = 1'b0; sel_ram = 1'b0;
      io_wr = 1'b1; io_addr = 8'hD8; io_wdata = 8'h00;
      n = 0;
      for (int k = 0; k < 8; k++) begin
         if (wait_o) n++;
         @(negedge clk);
         io_wr = 1'b0;
      end
      check("R6 mid-cycle write", n, 4);
      measure(3'b010, 2'd0, n);
      check("R6 new value next cycle", n, 0);

      // R9: I/O traffic and idle without a request give no wait
      io_write(8'hD8, 8'hFF);
      n = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         io_rd = 1'b1; io_addr = 8'hD8;
         #1 if (wait_o) n++;
      end
      @(negedge clk);
      io_rd = 1'b0;
      check("R9 no request no wait", n, 0);

      // R8: external wait drives output, then releases
      @(negedge clk);
      ext_wait = 1'b1;
      #1 check("R8 ext wait high", int'(wait_o), 1);
      @(negedge clk);
      ext_wait = 1'b0;
      #1 check("R8 ext wait released", int'(wait_o), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule